// File: doc/BRIEF.md
# Bus Master Release Sequencer

This block runs the ownership side of a DMA-capable peripheral that borrows a shared system bus from a host. When the peripheral needs the bus it raises a hold request. Once the host acknowledges, the block steps through four transfer states per bus cycle (T1 to T4). After the transfer flagged as the last one, it passes through two idle states (I1, I2) and then hands the bus back in a fixed order.

The order of the handback is as follows. The hold request is withdrawn first, on a rising edge of the bus clock. The address/data/parity group and the strobe group are then floated on the falling edge inside I1. The ownership and direction controls go inactive on the falling edge inside I2. Two bus styles are supported and differ only in when the request is withdrawn. In the first style (mode select low) the request is held until the last transfer ends. In the second style (mode select high) the request is withdrawn as soon as the first transfer reaches T2. A slave chip-select input is passed through only while the block does not own the bus.

Top module: `bus_release_seq`

## Requirements
- R1: While the synchronous active-high reset is asserted, the state reads RELEASED (code 0), `bus_req` is 0, both output enables are 0, and `own_n` and `dir` are 1.
- R2: In RELEASED, `dma_req` high moves the state to WAIT (code 1) at the next rising edge and sets `bus_req`. In WAIT, `hold_ack` high moves it to T1 (code 2).
- R3: The transfer states advance T1(2), T2(3), T3(4), T4(5) on successive rising edges. From T4 the state goes to T1 when `last_xfer` is 0 and to I1 (6) when it is 1. I1 is followed by I2 (7) and then by RELEASED.
- R4: With `mode_sel` = 0, `bus_req` stays 1 through every transfer state and falls at the rising edge that enters I1.
- R5: With `mode_sel` = 1, `bus_req` falls at the rising edge that enters T2 of the first transfer and stays 0 for the rest of the tenure.
- R6: `ad_oe` and `strb_oe` go to 1 at the falling edge inside T1 and to 0 at the falling edge inside I1.
- R7: `own_n` goes low at the falling edge inside T1 and goes high at the falling edge inside I2. `dir` is 0 for the same interval and 1 otherwise.
- R8: At every falling edge where `own_n` rises, `strb_oe` and `ad_oe` are already 0.
- R9: `cs_out` equals `cs_in` while `own_n` is 1 and is 0 while `own_n` is 0, so a slave access during T1 to I1 is held off until `own_n` rises in I2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| dma_req | input | 1 | Peripheral wants the bus |
| hold_ack | input | 1 | Host grants the bus |
| last_xfer | input | 1 | Current transfer is the final one |
| mode_sel | input | 1 | 0: request held to the end, 1: request dropped at first T2 |
| cs_in | input | 1 | Slave chip-select from the host side |
| bus_req | output | 1 | Hold request to the host |
| own_n | output | 1 | Bus ownership, active low |
| dir | output | 1 | Data-buffer direction, low while owning |
| ad_oe | output | 1 | Enable for address, data and parity drivers |
| strb_oe | output | 1 | Enable for read, write and byte-high strobes |
| cs_out | output | 1 | Gated slave chip-select |
| cyc_state | output | 3 | Current bus-cycle state code |

## Verification
The hardest condition to reach is a slave chip-select that arrives inside I1. It has to be held off even though the drivers are already floated, and then let through halfway into I2. The stimulus keeps `cs_in` high across whole tenures and toggles it in others. The scoreboard then compares `cs_out` against the expected ownership in every cycle. Multi-transfer tenures in both modes, with a variable number of waits for the grant, check that the request is withdrawn at exactly one edge and never reasserted within the same tenure.

// File: rtl/bus_release_pkg.sv
package bus_release_pkg;

   localparam int unsigned ST_W = 3;

   typedef enum logic [ST_W-1:0] {
      ST_REL  = 3'd0,
      ST_WAIT = 3'd1,
      ST_T1   = 3'd2,
      ST_T2   = 3'd3,
      ST_T3   = 3'd4,
      ST_T4   = 3'd5,
      ST_I1   = 3'd6,
      ST_I2   = 3'd7
   } bus_st_e;

   // Transfer states in which the block drives address, data and strobes
   function automatic logic in_xfer(bus_st_e s);
      return (s == ST_T1) || (s == ST_T2) || (s == ST_T3) || (s == ST_T4);
   endfunction

   // States in which ownership is still held at the falling edge
   function automatic logic in_tenure(bus_st_e s);
      return in_xfer(s) || (s == ST_I1);
   endfunction

endpackage

// File: rtl/bus_cycle_fsm.sv
module bus_cycle_fsm
   import bus_release_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  logic    dma_req,
   input  logic    hold_ack,
   input  logic    last_xfer,
   output bus_st_e state,
   output bus_st_e nxt
);

   always_comb begin
      nxt = state;
      unique case (state)
         ST_REL:  if (dma_req)  nxt = ST_WAIT;
         ST_WAIT: if (hold_ack) nxt = ST_T1;
         ST_T1:   nxt = ST_T2;
         ST_T2:   nxt = ST_T3;
         ST_T3:   nxt = ST_T4;
         ST_T4:   nxt = last_xfer ? ST_I1 : ST_T1;
         ST_I1:   nxt = ST_I2;
         ST_I2:   nxt = ST_REL;
         default: nxt = ST_REL;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_REL;
      else     state <= nxt;
   end

endmodule

// File: rtl/bus_req_ctrl.sv
module bus_req_ctrl
   import bus_release_pkg::*;
#(
   parameter bit EARLY_DROP_EN = 1'b1
)(
   input  logic    clk,
   input  logic    rst,
   input  bus_st_e state,
   input  bus_st_e nxt,
   input  logic    dma_req,
   input  logic    mode_sel,
   output logic    bus_req
);

   logic drop_late;
   logic drop_pt;
   logic raise_pt;

   assign drop_late = (state == ST_T4) && (nxt == ST_I1);
   assign raise_pt  = (state == ST_REL) && dma_req;

   generate
      if (EARLY_DROP_EN) begin : g_dual
         logic drop_early;
         assign drop_early = (state == ST_T1) && (nxt == ST_T2);
         assign drop_pt    = mode_sel ? drop_early : drop_late;
      end else begin : g_late_only
         logic unused_mode;
         assign unused_mode = mode_sel;
         assign drop_pt     = drop_late;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)           bus_req <= 1'b0;
      else if (raise_pt) bus_req <= 1'b1;
      else if (drop_pt)  bus_req <= 1'b0;
   end

endmodule

// File: rtl/bus_release_drv.sv
module bus_release_drv
   import bus_release_pkg::*;
#(
   parameter bit DIR_IDLE = 1'b1
)(
   input  logic    clk,
   input  logic    rst,
   input  bus_st_e state,
   input  logic    cs_in,
   output logic    ad_oe,
   output logic    strb_oe,
   output logic    own_n,
   output logic    dir,
   output logic    cs_out
);

   // Falling-edge stage: floats drivers in I1, lets go of ownership in I2
   always_ff @(negedge clk) begin
      if (rst) begin
         ad_oe   <= 1'b0;
         strb_oe <= 1'b0;
         own_n   <= 1'b1;
         dir     <= DIR_IDLE;
      end else begin
         ad_oe   <= in_xfer(state);
         strb_oe <= in_xfer(state);
         own_n   <= !in_tenure(state);
         dir     <= in_tenure(state) ? !DIR_IDLE : DIR_IDLE;
      end
   end

   assign cs_out = cs_in && own_n;

endmodule

// File: rtl/bus_release_seq.sv
module bus_release_seq
   import bus_release_pkg::*;
#(
   parameter bit          EARLY_DROP_EN = 1'b1,
   parameter bit          DIR_IDLE      = 1'b1,
   parameter int unsigned STATE_BITS    = 3
)(
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  dma_req,
   input  logic                  hold_ack,
   input  logic                  last_xfer,
   input  logic                  mode_sel,
   input  logic                  cs_in,
   output logic                  bus_req,
   output logic                  own_n,
   output logic                  dir,
   output logic                  ad_oe,
   output logic                  strb_oe,
   output logic                  cs_out,
   output logic [STATE_BITS-1:0] cyc_state
);

   localparam int unsigned NEED_W = ST_W;

   generate
      if (STATE_BITS != NEED_W) begin : g_bad_w
         $error("bus_release_seq: STATE_BITS must equal the state code width");
      end
   endgenerate

   bus_st_e state;
   bus_st_e nxt;

   bus_cycle_fsm u_fsm (
      .clk       (clk),
      .rst       (rst),
      .dma_req   (dma_req),
      .hold_ack  (hold_ack),
      .last_xfer (last_xfer),
      .state     (state),
      .nxt       (nxt)
   );

   bus_req_ctrl #(.EARLY_DROP_EN(EARLY_DROP_EN)) u_req (
      .clk      (clk),
      .rst      (rst),
      .state    (state),
      .nxt      (nxt),
      .dma_req  (dma_req),
      .mode_sel (mode_sel),
      .bus_req  (bus_req)
   );

   bus_release_drv #(.DIR_IDLE(DIR_IDLE)) u_drv (
      .clk     (clk),
      .rst     (rst),
      .state   (state),
      .cs_in   (cs_in),
      .ad_oe   (ad_oe),
      .strb_oe (strb_oe),
      .own_n   (own_n),
      .dir     (dir),
      .cs_out  (cs_out)
   );

   assign cyc_state = state;

endmodule

// File: rtl/bus_release_chk.sv
module bus_release_chk (
   input logic       clk,
   input logic       rst,
   input logic       mode_sel,
   input logic       last_xfer,
   input logic       bus_req,
   input logic       own_n,
   input logic       ad_oe,
   input logic       strb_oe,
   input logic       cs_in,
   input logic       cs_out,
   input logic [2:0] cyc_state
);

   // R3
   t1_to_t2_chk: assert property (@(posedge clk) disable iff (rst)
      (cyc_state == 3'd2) |=> (cyc_state == 3'd3));

   // R3
   t4_exit_chk: assert property (@(posedge clk) disable iff (rst)
      (cyc_state == 3'd5 && last_xfer) |=> (cyc_state == 3'd6));

   // R4
   late_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (cyc_state == 3'd5 && last_xfer && !mode_sel) |=> !bus_req);

   // R5
   early_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (cyc_state == 3'd2 && mode_sel) |=> !bus_req);

   // R4
   req_hold_mid_chk: assert property (@(posedge clk) disable iff (rst)
      (cyc_state == 3'd3 || cyc_state == 3'd4) |=> $stable(bus_req));

   // R6
   drive_on_chk: assert property (@(posedge clk) disable iff (rst)
      (cyc_state == 3'd3) |-> (ad_oe && strb_oe));

   // R7
   owned_low_chk: assert property (@(posedge clk) disable iff (rst)
      (cyc_state inside {3'd3, 3'd4, 3'd5, 3'd6}) |-> !own_n);

   // R8
   float_before_release_chk: assert property (@(negedge clk) disable iff (rst)
      $rose(own_n) |-> (!strb_oe && !ad_oe));

   // R9
   cs_blocked_chk: assert property (@(posedge clk) disable iff (rst)
      (!own_n && cs_in) |-> !cs_out);

endmodule

bind bus_release_seq bus_release_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .mode_sel  (mode_sel),
   .last_xfer (last_xfer),
   .bus_req   (bus_req),
   .own_n     (own_n),
   .ad_oe     (ad_oe),
   .strb_oe   (strb_oe),
   .cs_in     (cs_in),
   .cs_out    (cs_out),
   .cyc_state (cyc_state)
);

// File: tb/bus_release_seq_tb.sv
module bus_release_seq_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       dma_req = 1'b0, hold_ack = 1'b0, last_xfer = 1'b0;
   logic       mode_sel = 1'b0, cs_in = 1'b0;
   logic       bus_req, own_n, dir, ad_oe, strb_oe, cs_out;
   logic [2:0] cyc_state;

   int n_chk = 0;
   int n_err = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   typedef struct {
      logic [2:0] st;
      logic       req;
      logic       oe;
      logic       own_n;
      logic       cs;
      logic       mode;
   } snap_t;

   snap_t sb_q[$];

   // bench model state
   logic [2:0] m_st  = 3'd0;
   logic       m_req = 1'b0;

   always #10 clk = ~clk;

   bus_release_seq u_dut (
      .clk(clk), .rst(rst), .dma_req(dma_req), .hold_ack(hold_ack),
      .last_xfer(last_xfer), .mode_sel(mode_sel), .cs_in(cs_in),
      .bus_req(bus_req), .own_n(own_n), .dir(dir), .ad_oe(ad_oe),
      .strb_oe(strb_oe), .cs_out(cs_out), .cyc_state(cyc_state)
   );

   task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // one bus cycle: push expectation for this cycle, then drive inputs
   task automatic step(input logic dr, input logic ack, input logic lst,
                       input logic md, input logic cs);
      snap_t e;
      logic [2:0] nx;
      logic xfer, ten;
      @(posedge clk);
      #5;
      xfer = (m_st >= 3'd2) && (m_st <= 3'd5);
      ten  = xfer || (m_st == 3'd6);
      e.st = m_st; e.req = m_req; e.oe = xfer; e.own_n = !ten;
      e.cs = cs && !ten; e.mode = md;
      sb_q.push_back(e);
      dma_req = dr; hold_ack = ack; last_xfer = lst; mode_sel = md; cs_in = cs;
      case (m_st)
         3'd0: nx = dr ? 3'd1 : 3'd0;
         3'd1: nx = ack ? 3'd2 : 3'd1;
         3'd5: nx = lst ? 3'd6 : 3'd2;
         3'd7: nx = 3'd0;
         default: nx = m_st + 3'd1;
      endcase
      if (m_st == 3'd0 && dr) m_req = 1'b1;
      else if (!md && m_st == 3'd5 && nx == 3'd6) m_req = 1'b0;
      else if (md && m_st == 3'd2) m_req = 1'b0;
      m_st = nx;
   endtask

   task automatic tenure(input logic md, input int nx, input int waits, input bit cs_toggle);
      int k = 0;
      step(1, 0, 0, md, 1);
      for (int w = 0; w < waits; w++) step(0, 0, 0, md, cs_toggle ? logic'(w[0]) : 1'b1);
      step(0, 1, 0, md, 1);
      for (int i = 0; i < nx; i++) begin
         for (int p = 0; p < 3; p++) begin
            step(0, 1, 0, md, cs_toggle ? logic'(k[0]) : 1'b1);
            k++;
         end
         step(0, 1, (i == nx - 1), md, 1);
      end
      step(0, 0, 0, md, 1);   // I1: slave access held off
      step(0, 0, 0, md, 1);   // I2
      step(0, 0, 0, md, 1);   // RELEASED
      step(0, 0, 0, md, 0);
   endtask

   // monitor: pops expectations once falling-edge registers have settled
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (sb_q.size() > 0) begin
            snap_t e;
            e = sb_q.pop_front();
            chk("R2 R3 state", cyc_state, e.st);
            chk(e.mode ? "R5 bus_req" : "R4 bus_req", {2'b0, bus_req}, {2'b0, e.req});
            chk("R6 ad_oe", {2'b0, ad_oe}, {2'b0, e.oe});
            chk("R6 R8 strb_oe", {2'b0, strb_oe}, {2'b0, e.oe});
            chk("R7 own_n", {2'b0, own_n}, {2'b0, e.own_n});
            chk("R7 dir", {2'b0, dir}, {2'b0, e.own_n});
            chk("R9 cs_out", {2'b0, cs_out}, {2'b0, e.cs});
         end
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000 && !done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #12;
      // R1: reset values
      chk("R1 state", cyc_state, 3'd0);
      chk("R1 bus_req", {2'b0, bus_req}, 3'd0);
      chk("R1 ad_oe", {2'b0, ad_oe}, 3'd0);
      chk("R1 strb_oe", {2'b0, strb_oe}, 3'd0);
      chk("R1 own_n", {2'b0, own_n}, 3'd1);
      chk("R1 dir", {2'b0, dir}, 3'd1);
      @(posedge clk); #5; rst = 1'b0;
      tenure(1'b0, 2, 2, 1'b0);
      tenure(1'b1, 3, 0, 1'b1);
      tenure(1'b0, 1, 1, 1'b1);
      tenure(1'b1, 1, 3, 1'b0);
      while (sb_q.size() > 0) @(posedge clk);
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule